// File: doc/BRIEF.md
# Voltage and Temperature Conversion Scheduler

This block decides when a shared converter measures battery voltage and when it measures temperature. A 2-bit mode field selects one of four behaviours: idle, a single voltage measurement, a single temperature measurement, or a repeating voltage-then-temperature pair. Each measurement is started with a one-cycle start pulse and a channel select. When the converter reports completion, the block stores the 16-bit result in the matching result register. It then marks the converter as sleeping until the next measurement is due.

Writing the mode field is what triggers work. After a single measurement finishes, the field returns to idle. In repeating mode, the block counts a slow timebase tick after each pair completes and starts the next pair once a parameterised number of ticks has passed. The default count gives a two-second interval with a one-second tick. A mode write that arrives while a measurement is running is held and applied when that measurement ends.

Top module: `conv_sched`

## Requirements
- R1: After reset the mode readback is 00, `adc_sleep` is 1 and `adc_start` is 0.
- R2: Writing mode 10 while idle produces exactly one start pulse with `adc_chan`=0 (voltage). On `adc_done`, `adc_data` is stored in `volt_reg`, and then the mode reads 00 with `adc_sleep` high.
- R3: Writing mode 01 while idle produces exactly one start pulse with `adc_chan`=1 (temperature). On `adc_done`, `adc_data` is stored in `temp_reg`, and then the mode reads 00 with `adc_sleep` high.
- R4: Writing mode 11 starts a voltage measurement and then a temperature measurement, and the mode keeps reading 11. After the pair completes, exactly PERIOD_TICKS further `tick` pulses start the next pair, and PERIOD_TICKS-1 ticks do not.
- R5: With mode 00 no start pulse is issued, whatever the ticks.
- R6: A mode write while a measurement is in flight leaves the mode readback unchanged until that measurement completes. The running result is still stored in its own register, and the new mode then takes effect.
- R7: `adc_start` is high for one cycle at a time and never while `adc_sleep` is high. `adc_sleep` is low from that start pulse until `adc_done`.
- R8: An `adc_done` pulse while no measurement is in flight leaves both result registers and the mode unchanged.
- R9: Ticks in idle or after a single measurement start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode value: 00 idle, 01 temperature once, 10 voltage once, 11 repeating pair |
| tick | input | 1 | Slow timebase pulse |
| adc_done | input | 1 | Converter completion pulse |
| adc_data | input | DW | Converter result, valid with adc_done |
| adc_start | output | 1 | One-cycle measurement start |
| adc_chan | output | 1 | Channel: 0 voltage, 1 temperature |
| adc_sleep | output | 1 | High while no measurement is in flight |
| volt_reg | output | DW | Last voltage result |
| temp_reg | output | DW | Last temperature result |
| mode_rd | output | 2 | Mode readback |

## Verification
The assertions assume the converter raises `adc_done` for one cycle, at least one cycle after the start pulse. They also assume `adc_done` never comes with a start pulse in the same cycle. The behavioural converter in the bench counts a fixed latency of at least one cycle from each start it sees, so it keeps to this. Idle-time completion pulses are injected only when no measurement is in flight. Results are checked only after their first measurement, because the result registers have no reset value.

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int DW = 16,
  parameter int PERIOD_TICKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [1:0]    mode_wdata,
  input  logic          tick,
  input  logic          adc_done,
  input  logic [DW-1:0] adc_data,
  output logic          adc_start,
  output logic          adc_chan,
  output logic          adc_sleep,
  output logic [DW-1:0] volt_reg,
  output logic [DW-1:0] temp_reg,
  output logic [1:0]    mode_rd
);
  localparam int CW = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_TICKS - 1);

  logic [1:0]    mode_q, todo_q, pend_mode_q;
  logic          pend_q, busy_q, chan_q, start_q;
  logic [CW-1:0] wait_q;

  wire       launch     = !busy_q && (todo_q != 2'b00);
  wire       finish     = busy_q && adc_done;
  wire [1:0] todo_after = todo_q & ~(chan_q ? 2'b01 : 2'b10);
  wire       waiting    = !busy_q && (todo_q == 2'b00) && (mode_q == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'b00; todo_q <= 2'b00; pend_mode_q <= 2'b00;
      pend_q <= 1'b0; busy_q <= 1'b0; chan_q <= 1'b0; start_q <= 1'b0;
      wait_q <= '0;
    end else begin
      start_q <= launch;
      if (launch) begin
        busy_q <= 1'b1;
        chan_q <= !todo_q[1];
      end
      if (finish) begin
        busy_q <= 1'b0;
        todo_q <= todo_after;
        if (todo_after == 2'b00 && mode_q != 2'b11) mode_q <= 2'b00;
      end
      if (waiting && tick) begin
        if (wait_q == LAST) begin
          wait_q <= '0;
          todo_q <= 2'b11;
        end else begin
          wait_q <= wait_q + 1'b1;
        end
      end
      if (mode_wr && !busy_q && !launch) begin
        mode_q <= mode_wdata; todo_q <= mode_wdata; wait_q <= '0; pend_q <= 1'b0;
      end else if (mode_wr && !finish) begin
        pend_q <= 1'b1; pend_mode_q <= mode_wdata;
      end else if (mode_wr) begin
        mode_q <= mode_wdata; todo_q <= mode_wdata; wait_q <= '0; pend_q <= 1'b0;
      end else if (finish && pend_q) begin
        mode_q <= pend_mode_q; todo_q <= pend_mode_q; wait_q <= '0; pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (finish) begin
      if (chan_q) temp_reg <= adc_data;
      else        volt_reg <= adc_data;
    end
  end

  assign adc_start = start_q;
  assign adc_chan  = chan_q;
  assign adc_sleep = !busy_q;
  assign mode_rd   = mode_q;

  a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);
  a_r7_start_awake: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> !adc_sleep);
  a_r2_manual_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_done && !adc_sleep && mode_rd == 2'b10 && !pend_q && !mode_wr)
      |=> (mode_rd == 2'b00 && adc_sleep));
  a_r6_defer_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_sleep && mode_wr && !adc_done) |=> $stable(mode_rd));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd == 2'b00 && adc_sleep && !mode_wr && !pend_q) |=> !adc_start);
endmodule

// File: tb/conv_sched_bench.sv
module conv_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 3;

  logic clk = 0, rst_n = 0, mode_wr = 0, tick = 0, adc_done = 0;
  logic [1:0] mode_wdata = 0;
  logic [15:0] adc_data = 0;
  logic adc_start, adc_chan, adc_sleep;
  logic [15:0] volt_reg, temp_reg;
  logic [1:0] mode_rd;

  conv_sched #(.DW(16), .PERIOD_TICKS(PER)) u_conv_sched (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .tick(tick), .adc_done(adc_done), .adc_data(adc_data),
    .adc_start(adc_start), .adc_chan(adc_chan), .adc_sleep(adc_sleep),
    .volt_reg(volt_reg), .temp_reg(temp_reg), .mode_rd(mode_rd));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  int nstart = 0, cnt = 0, lat = 2;
  logic inj = 0, cur_chan = 0;
  logic [15:0] cur_data = 0, exp_v = 0, exp_t = 0;
  logic chan_log [0:63];

  always @(negedge clk) begin
    adc_done <= 1'b0;
    if (inj) begin
      adc_done <= 1'b1; adc_data <= 16'hDEAD;
    end else if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        adc_done <= 1'b1; adc_data <= cur_data;
        if (cur_chan) exp_t <= cur_data; else exp_v <= cur_data;
      end
    end else if (adc_start) begin
      cnt <= lat;
      cur_chan <= adc_chan;
      chan_log[nstart % 64] = adc_chan;
      cur_data <= 16'(16'h1357 * (nstart + 1)) ^ (adc_chan ? 16'hF0F0 : 16'h0000);
      nstart = nstart + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m);
    @(negedge clk); mode_wr = 1; mode_wdata = m;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic settle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (adc_sleep && !adc_start && cnt == 0 && !adc_done) q++; else q = 0;
    end
  endtask

  task automatic manual(input logic [1:0] m, input int l);
    int s0;
    logic [15:0] v0, t0;
    lat = l;
    s0 = nstart;
    wr(m);
    settle();
    chk(nstart == s0 + 1, (m == 2'b10) ? "R2 starts" : "R3 starts", nstart - s0, 1);
    chk(chan_log[s0 % 64] == (m == 2'b01), (m == 2'b10) ? "R2 chan" : "R3 chan",
        chan_log[s0 % 64], m == 2'b01);
    if (m == 2'b10) chk(volt_reg == exp_v, "R2 volt_reg", volt_reg, exp_v);
    else            chk(temp_reg == exp_t, "R3 temp_reg", temp_reg, exp_t);
    chk(mode_rd == 2'b00, "R2/R3 mode fallback", mode_rd, 0);
    chk(adc_sleep == 1'b1, "R7 sleep after", adc_sleep, 1);
    v0 = volt_reg; t0 = temp_reg;
    ticks(PER + 1);
    settle();
    chk(nstart == s0 + 1, "R9 no restart", nstart - s0, 1);
    if (m == 2'b10) chk(volt_reg == v0, "R9 volt stable", volt_reg, v0);
    else            chk(temp_reg == t0, "R9 temp stable", temp_reg, t0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    logic [15:0] v0, t0;
    repeat (3) @(negedge clk);
    chk(mode_rd == 2'b00, "R1 mode", mode_rd, 0);
    chk(adc_sleep == 1'b1, "R1 sleep", adc_sleep, 1);
    chk(adc_start == 1'b0, "R1 start", adc_start, 0);
    rst_n = 1;

    s0 = nstart;
    wr(2'b00); ticks(4); settle();
    chk(nstart == s0, "R5 idle no start", nstart - s0, 0);

    for (int l = 1; l <= 5; l += 2) begin
      manual(2'b10, l);
      manual(2'b01, l);
    end

    lat = 6;
    s0 = nstart;
    wr(2'b10);
    while (nstart == s0) @(negedge clk);
    wr(2'b01);
    chk(mode_rd == 2'b10, "R6 mode held", mode_rd, 2'b10);
    settle();
    chk(nstart == s0 + 2, "R6 both run", nstart - s0, 2);
    chk(chan_log[s0 % 64] == 1'b0 && chan_log[(s0 + 1) % 64] == 1'b1, "R6 order",
        {chan_log[s0 % 64], chan_log[(s0 + 1) % 64]}, 2'b01);
    chk(volt_reg == exp_v, "R6 volt kept", volt_reg, exp_v);
    chk(temp_reg == exp_t, "R6 temp after", temp_reg, exp_t);
    chk(mode_rd == 2'b00, "R6 mode end", mode_rd, 0);

    v0 = volt_reg; t0 = temp_reg;
    @(posedge clk); inj = 1; @(posedge clk); inj = 0;
    settle();
    chk(volt_reg == v0 && temp_reg == t0, "R8 regs unchanged", {volt_reg, temp_reg}, {v0, t0});
    chk(mode_rd == 2'b00, "R8 mode unchanged", mode_rd, 0);

    lat = 3;
    s0 = nstart;
    wr(2'b11);
    settle();
    for (int p = 0; p < 3; p++) begin
      chk(nstart == s0 + 2, "R4 pair count", nstart - s0, 2);
      chk(chan_log[s0 % 64] == 1'b0 && chan_log[(s0 + 1) % 64] == 1'b1, "R4 order",
          {chan_log[s0 % 64], chan_log[(s0 + 1) % 64]}, 2'b01);
      chk(volt_reg == exp_v && temp_reg == exp_t, "R4 results", {volt_reg, temp_reg}, {exp_v, exp_t});
      chk(mode_rd == 2'b11, "R4 mode kept", mode_rd, 2'b11);
      ticks(PER - 1); settle();
      chk(nstart == s0 + 2, "R4 early tick", nstart - s0, 2);
      s0 = nstart;
      ticks(1); settle();
    end

    s0 = nstart;
    wr(2'b00); ticks(PER * 2); settle();
    chk(nstart == s0, "R5 stop", nstart - s0, 0);
    chk(mode_rd == 2'b00, "R5 mode", mode_rd, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule